// File: doc/BRIEF.md
# Loop Index Counter with Terminal-Count Skip

This block is a wide counter register for loop control. Software-visible sequencing loads a start value into it, then steps it up or down by one per command. After each step the block decides whether the loop has reached its terminal value and, if it has, raises a skip pulse. The surrounding sequencer uses that pulse to jump over the next instruction. The register holds 68 bits, but stepping works on the low 64 bits only.

What counts as the terminal value depends on the number representation: unsigned, one's complement or two's complement. The representation is captured at the moment the register is loaded, and that captured mode drives every later test. The current mode input is still consulted in one case. If the captured mode is one's complement and the current mode is unsigned, the test follows the two's complement rule.

Top module: `idx_loop_counter`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `count_o` is zero and `skip_o` is low.
- R2: A load writes all 68 bits of `load_val_i` into `count_o` by the next cycle. A load wins over an increment or decrement in the same cycle, and that cycle produces no skip.
- R3: An increment adds one to the low 64 bits modulo 2^64 and clears bits 67..64.
- R4: A decrement subtracts one from the low 64 bits modulo 2^64 and clears bits 67..64.
- R5: Mode codes on `mode_i` are 0 unsigned, 1 one's complement, 2 two's complement, and 3, which is handled as unsigned. With an unsigned captured mode, no step ever raises `skip_o`.
- R6: With one's complement captured, and the current mode not unsigned, an increment skips exactly when the new low 64 bits are all ones.
- R7: With two's complement in effect, an increment or a decrement skips exactly when the new low 64 bits are all zeros.
- R8: With one's complement captured, and the current mode not unsigned, a decrement skips when the new low 64 bits are all zeros or all ones.
- R9: The test uses the mode captured at the last load. A mode change without a load has no effect, except as stated in R10.
- R10: If the captured mode is one's complement and `mode_i` is unsigned during the step, the two's complement rule of R7 applies.
- R11: `skip_o` is high only in the cycle after a step that met its test. It is low after any cycle without a step.
- R12: When `inc_i` and `dec_i` are both high without a load, the step is an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 68 | Value to load |
| mode_i | input | 2 | Current representation mode |
| inc_i | input | 1 | Increment-and-test strobe |
| dec_i | input | 1 | Decrement-and-test strobe |
| count_o | output | 68 | Register value |
| skip_o | output | 1 | One-cycle skip pulse |

## Verification
Every result of this block is due one clock edge after the strobe that causes it. The new value, the captured mode and the skip pulse all appear together after the edge that samples a load or a step. The driver applies inputs on the falling edge and queues the value and skip it expects from those inputs. The monitor then compares a quarter period after the next rising edge, so each expectation is matched against exactly the edge that consumed its stimulus. Idle cycles are also queued, which lets the bench catch a skip that lingers past its single cycle.

// File: rtl/idx_pkg.sv
package idx_pkg;
  typedef enum logic [1:0] {
    CM_UNSIGNED = 2'd0,
    CM_ONES     = 2'd1,
    CM_TWOS     = 2'd2,
    CM_RSVD     = 2'd3
  } cmode_e;

  // Reserved code collapses to unsigned.
  function automatic cmode_e norm_mode(input logic [1:0] code);
    cmode_e m;
    m = cmode_e'(code);
    if (m == CM_RSVD) m = CM_UNSIGNED;
    return m;
  endfunction
endpackage

// File: rtl/idx_mode_latch.sv
module idx_mode_latch
  import idx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [1:0] mode_i,
  output cmode_e     eff_mode_o
);
  cmode_e held_q;
  cmode_e cur_mode;

  assign cur_mode = norm_mode(mode_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= CM_UNSIGNED;
    else if (load_i) held_q <= cur_mode;
  end

  // Captured one's complement read under current unsigned takes the two's rule.
  function automatic cmode_e pick_mode(input cmode_e held, input cmode_e cur);
    if (held == CM_ONES && cur == CM_UNSIGNED) return CM_TWOS;
    return held;
  endfunction

  assign eff_mode_o = pick_mode(held_q, cur_mode);

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(held_q));
  assert_mode_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    held_q != CM_RSVD);
endmodule

// File: rtl/idx_count_reg.sv
module idx_count_reg #(
  parameter int REG_W = 68,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [REG_W-1:0] count_o,
  output logic             step_o,
  output logic             up_o,
  output logic [CNT_W-1:0] next_low_o
);
  localparam int EXT_W = REG_W - CNT_W;

  logic [REG_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] v, input logic up);
    if (up) return v + {{(CNT_W-1){1'b0}}, 1'b1};
    return v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign step_o     = !load_i && (inc_i || dec_i);
  assign up_o       = inc_i;
  assign next_low_o = advance(cnt_q[CNT_W-1:0], up_o);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_o) cnt_q <= {{EXT_W{1'b0}}, next_low_o};
  end

  assign count_o = cnt_q;

  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(load_val_i));
  assert_inc_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && up_o) |=> count_o[CNT_W-1:0] == $past(count_o[CNT_W-1:0]) + 1'b1);
  assert_dec_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_o && !up_o) |=> count_o[CNT_W-1:0] == $past(count_o[CNT_W-1:0]) - 1'b1);
  assert_ext_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> count_o[REG_W-1:CNT_W] == '0);
endmodule

// File: rtl/idx_skip_judge.sv
module idx_skip_judge
  import idx_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  cmode_e           eff_mode_i,
  input  logic [CNT_W-1:0] result_i,
  output logic             skip_o
);
  logic skip_q;
  logic hit;

  function automatic logic terminal(input cmode_e m, input logic up, input logic [CNT_W-1:0] r);
    logic zero, ones;
    zero = (r == '0);
    ones = &r;
    case (m)
      CM_TWOS: return zero;
      CM_ONES: return up ? ones : (ones || zero);
      default: return 1'b0;
    endcase
  endfunction

  assign hit = step_i && terminal(eff_mode_i, up_i, result_i);

  always_ff @(posedge clk) begin
    if (!rst_n) skip_q <= 1'b0;
    else        skip_q <= hit;
  end

  assign skip_o = skip_q;

  assert_no_skip_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> !skip_o);
  assert_no_skip_uns_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && eff_mode_i == CM_UNSIGNED) |=> !skip_o);
  assert_twos_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && eff_mode_i == CM_TWOS) |=> skip_o == ($past(result_i) == '0));
endmodule

// File: rtl/idx_loop_counter.sv
module idx_loop_counter
  import idx_pkg::*;
#(
  parameter int REG_W = 68,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] load_val_i,
  input  logic [1:0]       mode_i,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [REG_W-1:0] count_o,
  output logic             skip_o
);
  logic             step_w;
  logic             up_w;
  logic [CNT_W-1:0] next_low_w;
  cmode_e           eff_mode_w;

  idx_mode_latch i_mode (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .mode_i(mode_i),
    .eff_mode_o(eff_mode_w)
  );

  idx_count_reg #(.REG_W(REG_W), .CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .inc_i(inc_i), .dec_i(dec_i), .count_o(count_o),
    .step_o(step_w), .up_o(up_w), .next_low_o(next_low_w)
  );

  idx_skip_judge #(.CNT_W(CNT_W)) i_skip (
    .clk(clk), .rst_n(rst_n), .step_i(step_w), .up_i(up_w),
    .eff_mode_i(eff_mode_w), .result_i(next_low_w), .skip_o(skip_o)
  );

  assert_load_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !skip_o);
  assert_both_is_inc_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && inc_i && dec_i) |=> count_o[CNT_W-1:0] == $past(count_o[CNT_W-1:0]) + 1'b1);
endmodule

// File: tb/test_idx_loop_counter.sv
module test_idx_loop_counter;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 68;
  localparam int CW = 64;

  typedef struct {
    logic [RW-1:0] val;
    logic          skip;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_i = 1'b0;
  logic [RW-1:0] load_val_i = '0;
  logic [1:0]    mode_i = 2'd0;
  logic          inc_i = 1'b0;
  logic          dec_i = 1'b0;
  logic [RW-1:0] count_o;
  logic          skip_o;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];

  // bench model state
  logic [RW-1:0] m_val = '0;
  logic [1:0]    m_mode = 2'd0;

  idx_loop_counter i_idx_loop_counter (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_val_i(load_val_i),
    .mode_i(mode_i), .inc_i(inc_i), .dec_i(dec_i),
    .count_o(count_o), .skip_o(skip_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  localparam logic [CW-1:0] ALL1 = {CW{1'b1}};

  task automatic cyc(input logic ld, input logic [RW-1:0] v, input logic [1:0] md,
                     input logic up, input logic dn, input string tag);
    exp_t e;
    logic [1:0] held, cur, rule;
    logic [CW-1:0] low;
    @(negedge clk);
    load_i = ld; load_val_i = v; mode_i = md; inc_i = up; dec_i = dn;
    e.skip = 1'b0;
    if (ld) begin
      m_val = v;
      m_mode = (md == 2'd3) ? 2'd0 : md;
    end else if (up || dn) begin
      low = up ? (m_val[CW-1:0] + 64'd1) : (m_val[CW-1:0] + ALL1);
      m_val = {4'h0, low};
      held = m_mode;
      cur = (md == 2'd3) ? 2'd0 : md;
      rule = (held == 2'd1 && cur == 2'd0) ? 2'd2 : held;
      if (rule == 2'd2) e.skip = (low == 64'd0);
      else if (rule == 2'd1) e.skip = up ? (low == ALL1) : (low == ALL1 || low == 64'd0);
    end
    e.val = m_val;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, '0, mode_i, 1'b0, 1'b0, tag);
  endtask

  // monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    exp_t e;
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (count_o !== e.val || skip_o !== e.skip) begin
        errors++;
        $display("FAIL %s: count=%h skip=%b expected count=%h skip=%b",
                 e.tag, count_o, skip_o, e.val, e.skip);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*20000);
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (count_o !== '0 || skip_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: count=%h skip=%b expected count=0 skip=0", count_o, skip_o);
    end
    @(negedge clk); rst_n = 1'b1;
    idle("R1 after reset");
    // R2 load full width, load over step
    cyc(1, 68'hA_0000_0000_0000_0005, 2'd2, 0, 0, "R2 load");
    cyc(1, 68'h3_0000_0000_0000_0000, 2'd2, 1, 0, "R2 load beats inc");
    cyc(0, '0, 2'd2, 1, 0, "R3 inc clears upper");
    // R7 / R3 wrap in two's
    cyc(1, {4'h5, ALL1 - 64'd1}, 2'd2, 0, 0, "R2 load twos");
    cyc(0, '0, 2'd2, 1, 0, "R7 inc to all ones no skip");
    cyc(0, '0, 2'd2, 1, 0, "R7 R3 inc wraps to zero skip");
    idle("R11 pulse ends");
    cyc(0, '0, 2'd2, 0, 1, "R4 dec from zero");
    cyc(1, 68'd1, 2'd2, 0, 0, "R2 load one");
    cyc(0, '0, 2'd2, 0, 1, "R7 dec to zero skip");
    idle("R11 idle");
    // R5 unsigned
    cyc(1, {4'h0, ALL1}, 2'd0, 0, 0, "R5 load uns");
    cyc(0, '0, 2'd0, 1, 0, "R5 inc wrap no skip");
    cyc(0, '0, 2'd0, 0, 1, "R5 dec no skip");
    cyc(1, 68'd1, 2'd3, 0, 0, "R5 load code3");
    cyc(0, '0, 2'd3, 0, 1, "R5 code3 dec to zero no skip");
    // R6 ones
    cyc(1, {4'h0, ALL1 - 64'd1}, 2'd1, 0, 0, "R6 load ones");
    cyc(0, '0, 2'd1, 1, 0, "R6 inc to all ones skip");
    cyc(0, '0, 2'd1, 1, 0, "R6 inc to zero no skip");
    // R8 ones dec
    cyc(1, 68'd1, 2'd1, 0, 0, "R8 load");
    cyc(0, '0, 2'd1, 0, 1, "R8 dec to zero skip");
    cyc(0, '0, 2'd1, 0, 1, "R8 dec to all ones skip");
    cyc(0, '0, 2'd1, 0, 1, "R8 dec plain no skip");
    // R9 latched mode honoured
    cyc(1, {4'h0, ALL1}, 2'd2, 0, 0, "R9 load twos");
    cyc(0, '0, 2'd1, 1, 0, "R9 twos held under ones");
    cyc(1, {4'h0, ALL1 - 64'd1}, 2'd0, 0, 0, "R9 load uns");
    cyc(0, '0, 2'd1, 1, 0, "R9 uns held under ones");
    cyc(0, '0, 2'd2, 1, 0, "R9 uns held under twos");
    // R10 ones captured, unsigned current
    cyc(1, {4'h0, ALL1 - 64'd1}, 2'd1, 0, 0, "R10 load ones");
    cyc(0, '0, 2'd0, 1, 0, "R10 to all ones no skip");
    cyc(0, '0, 2'd0, 1, 0, "R10 to zero skip");
    cyc(1, 68'd2, 2'd1, 0, 0, "R10 load ones");
    cyc(0, '0, 2'd3, 0, 1, "R10 code3 dec plain");
    cyc(0, '0, 2'd0, 0, 1, "R10 dec to zero skip");
    // R12 both strobes
    cyc(1, 68'd7, 2'd2, 0, 0, "R12 load");
    cyc(0, '0, 2'd2, 1, 1, "R12 both is inc");
    cyc(1, {4'h0, ALL1}, 2'd2, 0, 0, "R12 load");
    cyc(0, '0, 2'd2, 1, 1, "R12 both wraps skip");
    idle("R11 final idle");
    idle("R11 final idle 2");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule